// File: doc/BRIEF.md
# Receive Character Recognition and Stripping

This block sits in a UART receive path between the deserializer and the receive FIFO. Every received character is compared against three programmable match characters: a flow-resume character, a flow-stop character and a multi-drop address (wake-up) character. When a character matches, the block does three things:

- It sets a per-character recognition status bit and a summary interrupt-status bit.
- It raises an interrupt if that character's interrupt is enabled.
- It drives a flow-control request that stops or resumes the local transmitter. The transmitter only changes state at a character boundary.

A 2-bit mode field can discard matched characters from the data stream. Their recognition actions still take effect. A character that arrives flagged with a receive error always reaches the FIFO, whatever the stripping mode. In multi-drop mode, characters are forwarded only while the block is awake, and matching the address character wakes it.

Configuration goes through a small write port with four locations. Location 0 holds the resume character, location 1 the stop character, location 2 the address character, and location 3 the mode register. Writing the mode register with its top bit set acts as a software reset.

Top module: `rx_match_strip`

## Requirements
- R1: After `rst` (or a software reset) the resume character is 0x11, the stop character is 0x13, the address character is 0x00 and the mode register is 0. `fifo_we`, `fifo_data`, `fifo_err`, `recog_stat`, `isr_recog`, `irq`, `tx_halt` and `awake` are all 0.
- R2: A write with `cfg_sel` = 0, 1 or 2 loads the resume, stop or address character. A character arriving in the same cycle as the write is still compared against the old value.
- R3: A received character equal to the resume, stop or address character sets `recog_stat` bit 0, 1 or 2 respectively, one clock after `rx_valid`. `isr_recog` is the OR of the status bits, on the same timing.
- R4: A cycle with `stat_rd` high clears `recog_stat` on the next clock. A match in that same cycle still sets its bit: set wins over clear.
- R5: The mode register is written with `cfg_sel` = 3. Mode bits [5:3] enable interrupts for the resume, stop and address bits. `irq` is high whenever an enabled status bit is set, with the same timing as the status.
- R6: Mode bits [1:0] select stripping:
  - 00: nothing is stripped.
  - 01: the resume and stop characters are stripped.
  - 10: the address character is stripped.
  - 11: all three are stripped.

  Every character that is not stripped (and is allowed by R11) gives a one-cycle `fifo_we` pulse, with `fifo_data` and `fifo_err`, on the clock after `rx_valid`.
- R7: A stripped character still performs its recognition actions: status, interrupt, flow control and wake-up.
- R8: A character received with `rx_err` high is written to the FIFO even when its match would otherwise strip it.
- R9: A stop match raises the halt request and a resume match clears it. If one character matches both, the stop match wins.
- R10: `tx_halt` takes the current halt request only on a clock where `tx_boundary` is high. At all other times it holds its value.
- R11: Mode bit [2] enables multi-drop mode.
  - In multi-drop mode, characters are forwarded only while `awake` is set, or when the character itself matches the address character.
  - An address match sets `awake`.
  - Any write to the mode register clears `awake`.
  - With bit [2] clear, every character is eligible for forwarding.
- R12: A mode-register write with bit 7 set restores the R1 state on the next clock. It also discards any character received in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Strobe for one received character |
| rx_data | input | CHAR_W | Received character |
| rx_err | input | 1 | Error flag of the received character |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Location: 0 resume, 1 stop, 2 address, 3 mode |
| cfg_wdata | input | CHAR_W | Configuration write data |
| stat_rd | input | 1 | Recognition status read; clears the status bits |
| tx_boundary | input | 1 | Transmitter is between characters |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | CHAR_W | Character for the FIFO |
| fifo_err | output | 1 | Error flag for the FIFO |
| recog_stat | output | 3 | Recognition status: bit 0 resume, bit 1 stop, bit 2 address |
| isr_recog | output | 1 | Recognition bit of the main interrupt status |
| irq | output | 1 | Interrupt request |
| tx_halt | output | 1 | Local transmitter halt |
| awake | output | 1 | Multi-drop wake state |

## Verification
Two pairs of functions can fall in the same cycle:

- **Status read and new match.** A status read that clears the recognition bits can meet a new match that sets one. The bench provokes this in directed steps and in the random phase by raising `stat_rd` in the same cycle as a matching character. The behavioural model expects set to win, so the bit stays set afterwards.
- **Mode write and address match.** A mode-register write that sends the block to sleep can coincide with an address match that wakes it. Here the mode write wins.

The model compares every output on every clock.

// File: rtl/rxcr_pkg.sv
package rxcr_pkg;
  localparam int N_CHR   = 3;
  localparam int IDX_ON  = 0;
  localparam int IDX_OFF = 1;
  localparam int IDX_ADR = 2;

  localparam logic [7:0] DEF_ON_CHR  = 8'h11;
  localparam logic [7:0] DEF_OFF_CHR = 8'h13;
  localparam logic [7:0] DEF_ADR_CHR = 8'h00;

  typedef enum logic [1:0] {
    SEL_ON   = 2'd0,
    SEL_OFF  = 2'd1,
    SEL_ADR  = 2'd2,
    SEL_MODE = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    STRIP_NONE = 2'd0,
    STRIP_FLOW = 2'd1,
    STRIP_WAKE = 2'd2,
    STRIP_ALL  = 2'd3
  } strip_e;

  // mode register layout: [5:3] irq enables, [2] multi-drop, [1:0] strip
  typedef struct packed {
    logic [N_CHR-1:0] irq_en;
    logic             multidrop;
    strip_e           strip;
  } mode_t;
endpackage

// File: rtl/rxcr_cfg.sv
module rxcr_cfg
  import rxcr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_sel,
  input  logic [CHAR_W-1:0]             cfg_wdata,
  output logic [N_CHR-1:0][CHAR_W-1:0]  chr_q,
  output mode_t                         mode_q,
  output logic                          mode_wr,
  output logic                          soft_rst
);
  localparam int MODE_W = $bits(mode_t);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata[CHAR_W-2:MODE_W];

  always_comb begin
    mode_wr  = cfg_we && (cfg_sel == SEL_MODE);
    soft_rst = mode_wr && cfg_wdata[CHAR_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      chr_q[IDX_ON]  <= CHAR_W'(DEF_ON_CHR);
      chr_q[IDX_OFF] <= CHAR_W'(DEF_OFF_CHR);
      chr_q[IDX_ADR] <= CHAR_W'(DEF_ADR_CHR);
      mode_q         <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_ON:  chr_q[IDX_ON]  <= cfg_wdata;
        SEL_OFF: chr_q[IDX_OFF] <= cfg_wdata;
        SEL_ADR: chr_q[IDX_ADR] <= cfg_wdata;
        default: mode_q         <= mode_t'(cfg_wdata[MODE_W-1:0]);
      endcase
    end
  end
endmodule

// File: rtl/rxcr_match.sv
module rxcr_match
  import rxcr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0]             rx_data,
  input  logic [N_CHR-1:0][CHAR_W-1:0]  chr,
  input  strip_e                        strip,
  output logic [N_CHR-1:0]              hit,
  output logic                          strip_hit
);
  logic [N_CHR-1:0] strip_mask;

  for (genvar g = 0; g < N_CHR; g++) begin : g_cmp
    // strip bit 0 covers the flow-control characters, bit 1 the address one
    localparam int SBIT = (g == IDX_ADR) ? 1 : 0;
    assign hit[g]        = (rx_data == chr[g]);
    assign strip_mask[g] = strip[SBIT];
  end

  assign strip_hit = |(hit & strip_mask);
endmodule

// File: rtl/rxcr_state.sv
module rxcr_state
  import rxcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             mode_wr,
  input  logic             rx_valid,
  input  logic [N_CHR-1:0] hit,
  input  logic             stat_rd,
  input  logic [N_CHR-1:0] irq_en,
  input  logic             multidrop,
  input  logic             tx_boundary,
  output logic             wake_ok,
  output logic [N_CHR-1:0] stat_q,
  output logic             isr_q,
  output logic             irq_q,
  output logic             tx_halt_q,
  output logic             awake_q
);
  logic [N_CHR-1:0] hit_v, stat_nxt;
  logic             halt_req_q, halt_nxt, awake_nxt;

  always_comb begin
    hit_v    = rx_valid ? hit : '0;
    stat_nxt = (stat_rd ? '0 : stat_q) | hit_v;
    if (hit_v[IDX_OFF])     halt_nxt = 1'b1;
    else if (hit_v[IDX_ON]) halt_nxt = 1'b0;
    else                    halt_nxt = halt_req_q;
    awake_nxt = mode_wr ? 1'b0 : (awake_q | hit_v[IDX_ADR]);
    wake_ok   = !multidrop || awake_q || hit[IDX_ADR];
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      stat_q     <= '0;
      isr_q      <= 1'b0;
      irq_q      <= 1'b0;
      halt_req_q <= 1'b0;
      tx_halt_q  <= 1'b0;
      awake_q    <= 1'b0;
    end else begin
      stat_q     <= stat_nxt;
      isr_q      <= |stat_nxt;
      irq_q      <= |(stat_nxt & irq_en);
      halt_req_q <= halt_nxt;
      if (tx_boundary) tx_halt_q <= halt_nxt;
      awake_q    <= awake_nxt;
    end
  end

  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rx_valid && !soft_rst) |=> (stat_q == '0));
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && hit[IDX_OFF] && !soft_rst) |=> stat_q[IDX_OFF]);
  p_stop_halts_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && hit[IDX_OFF] && !soft_rst) |=> halt_req_q);
  p_halt_boundary_r10: assert property (@(posedge clk) disable iff (rst)
    (!tx_boundary && !soft_rst) |=> $stable(tx_halt_q));
  p_irq_needs_isr_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> isr_q);
  p_addr_wakes_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && hit[IDX_ADR] && !mode_wr) |=> awake_q);
endmodule

// File: rtl/rx_match_strip.sv
module rx_match_strip
  import rxcr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_err,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CHAR_W-1:0] cfg_wdata,
  input  logic              stat_rd,
  input  logic              tx_boundary,
  output logic              fifo_we,
  output logic [CHAR_W-1:0] fifo_data,
  output logic              fifo_err,
  output logic [2:0]        recog_stat,
  output logic              isr_recog,
  output logic              irq,
  output logic              tx_halt,
  output logic              awake
);
  logic [N_CHR-1:0][CHAR_W-1:0] chr_q;
  mode_t                        mode_q;
  logic                         mode_wr, soft_rst;
  logic [N_CHR-1:0]             hit;
  logic                         strip_hit, wake_ok, keep;

  rxcr_cfg #(.CHAR_W(CHAR_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .chr_q(chr_q), .mode_q(mode_q),
    .mode_wr(mode_wr), .soft_rst(soft_rst)
  );

  rxcr_match #(.CHAR_W(CHAR_W)) u_match (
    .rx_data(rx_data), .chr(chr_q), .strip(mode_q.strip),
    .hit(hit), .strip_hit(strip_hit)
  );

  rxcr_state u_state (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .mode_wr(mode_wr),
    .rx_valid(rx_valid), .hit(hit), .stat_rd(stat_rd),
    .irq_en(mode_q.irq_en), .multidrop(mode_q.multidrop),
    .tx_boundary(tx_boundary), .wake_ok(wake_ok), .stat_q(recog_stat),
    .isr_q(isr_recog), .irq_q(irq), .tx_halt_q(tx_halt), .awake_q(awake)
  );

  // an errored character is never discarded by stripping
  assign keep = wake_ok && !(strip_hit && !rx_err);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      fifo_we   <= 1'b0;
      fifo_data <= '0;
      fifo_err  <= 1'b0;
    end else begin
      fifo_we <= rx_valid && keep;
      if (rx_valid) begin
        fifo_data <= rx_data;
        fifo_err  <= rx_err;
      end
    end
  end

  p_err_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_err && wake_ok && !soft_rst) |=> fifo_we);
  p_no_spurious_write_r6: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !fifo_we);
  p_asleep_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && mode_q.multidrop && !awake && !hit[IDX_ADR]) |=> !fifo_we);
  p_soft_reset_r12: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!fifo_we && !tx_halt && !awake && recog_stat == '0));
endmodule

// File: tb/rx_match_strip_bench.sv
module rx_match_strip_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_err = 1'b0, cfg_we = 1'b0, stat_rd = 1'b0;
  logic tx_boundary = 1'b1;
  logic [7:0] rx_data = '0, cfg_wdata = '0;
  logic [1:0] cfg_sel = '0;
  logic fifo_we, fifo_err, isr_recog, irq, tx_halt, awake;
  logic [7:0] fifo_data;
  logic [2:0] recog_stat;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1 reset";

  // reference model state
  logic [7:0] m_on, m_off, m_adr, m_mode, m_fdata;
  logic [2:0] m_stat;
  logic m_halt_req, m_halt, m_awake, m_fwe, m_ferr, m_irq, m_isr;

  always #10 clk = ~clk;

  rx_match_strip u_rx_match_strip (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .tx_boundary(tx_boundary),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .fifo_err(fifo_err),
    .recog_stat(recog_stat), .isr_recog(isr_recog), .irq(irq),
    .tx_halt(tx_halt), .awake(awake)
  );

  task automatic model_init();
    m_on = 8'h11; m_off = 8'h13; m_adr = 8'h00; m_mode = 8'h00;
    m_fdata = 8'h00; m_stat = 3'b000;
    m_halt_req = 0; m_halt = 0; m_awake = 0; m_fwe = 0; m_ferr = 0;
    m_irq = 0; m_isr = 0;
  endtask

  task automatic model_step();
    bit hon, hoff, hadr, stripped, eligible;
    if (rst || (cfg_we && cfg_sel == 2'd3 && cfg_wdata[7])) begin
      model_init();
      return;
    end
    hon  = rx_valid && rx_data == m_on;
    hoff = rx_valid && rx_data == m_off;
    hadr = rx_valid && rx_data == m_adr;
    case (m_mode[1:0])
      2'b00: stripped = 0;
      2'b01: stripped = hon || hoff;
      2'b10: stripped = hadr;
      default: stripped = hon || hoff || hadr;
    endcase
    eligible = !m_mode[2] || m_awake || hadr;
    m_fwe = rx_valid && eligible && (!stripped || rx_err);
    if (rx_valid) begin
      m_fdata = rx_data;
      m_ferr  = rx_err;
    end
    if (stat_rd) m_stat = 3'b000;
    if (hon)  m_stat[0] = 1;
    if (hoff) m_stat[1] = 1;
    if (hadr) m_stat[2] = 1;
    if (hoff) m_halt_req = 1;
    else if (hon) m_halt_req = 0;
    if (tx_boundary) m_halt = m_halt_req;
    if (hadr) m_awake = 1;
    if (cfg_we && cfg_sel == 2'd3) m_awake = 0;
    m_isr = m_stat != 0;
    m_irq = (m_stat & m_mode[5:3]) != 0;
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: m_on  = cfg_wdata;
        2'd1: m_off = cfg_wdata;
        2'd2: m_adr = cfg_wdata;
        default: m_mode = {2'b00, cfg_wdata[5:0]};
      endcase
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s act=%h exp=%h", phase, tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R6 fifo_we", 8'(fifo_we), 8'(m_fwe));
    if (m_fwe) begin
      chk("R6 fifo_data", fifo_data, m_fdata);
      chk("R8 fifo_err", 8'(fifo_err), 8'(m_ferr));
    end
    chk("R3 recog_stat", 8'(recog_stat), 8'(m_stat));
    chk("R3 isr_recog", 8'(isr_recog), 8'(m_isr));
    chk("R5 irq", 8'(irq), 8'(m_irq));
    chk("R10 tx_halt", 8'(tx_halt), 8'(m_halt));
    chk("R11 awake", 8'(awake), 8'(m_awake));
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic e);
    rx_valid = v; rx_data = d; rx_err = e;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    rx_valid = 0; rx_err = 0; cfg_we = 0; stat_rd = 0;
  endtask

  task automatic rx(input logic [7:0] d, input logic e = 0);
    step(1, d, e);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    step(0, 8'h00, 0);
  endtask

  initial begin
    model_init();
    repeat (3) step(0, 8'h00, 0);
    rst = 0;
    phase = "R1 reset";
    step(0, 8'h00, 0);
    chk("R1 outputs idle", {fifo_we, isr_recog, irq, tx_halt, awake, recog_stat}, 8'h00);

    phase = "R1,R3 default chars";
    rx(8'h41); rx(8'h11); rx(8'h13); rx(8'h00); step(0, 0, 0);

    phase = "R4 read clear, set wins";
    stat_rd = 1; step(0, 0, 0);
    stat_rd = 1; rx(8'h13);
    stat_rd = 1; rx(8'h55);
    chk("R4 cleared", 8'(recog_stat), 8'h00);

    phase = "R2 program chars";
    cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 8'h51; rx(8'h51);
    wr(2'd1, 8'h53); wr(2'd2, 8'hA5);
    rx(8'h51); rx(8'h53); rx(8'hA5); rx(8'h11); rx(8'h13);

    phase = "R5 irq enables";
    stat_rd = 1; step(0, 0, 0);
    wr(2'd3, 8'b00_010_000); rx(8'h51); rx(8'hA5);
    rx(8'h53);
    chk("R5 irq on stop", 8'(irq), 8'h01);
    stat_rd = 1; step(0, 0, 0);

    phase = "R6,R7 strip modes";
    for (int m = 0; m < 4; m++) begin
      wr(2'd3, 8'(m) | 8'h38);
      rx(8'h51); rx(8'h53); rx(8'hA5); rx(8'h77);
      stat_rd = 1; step(0, 0, 0);
    end

    phase = "R8 errored chars kept";
    wr(2'd3, 8'h03);
    rx(8'h53, 1); rx(8'hA5, 1); rx(8'h51, 1); rx(8'h53, 0);
    chk("R8 stripped clean stop", 8'(fifo_we), 8'h00);

    phase = "R9,R10 halt at boundary";
    tx_boundary = 0; rx(8'h53); step(0, 0, 0);
    chk("R10 held off boundary", 8'(tx_halt), 8'(m_halt));
    tx_boundary = 1; step(0, 0, 0);
    tx_boundary = 0; rx(8'h51); step(0, 0, 0);
    tx_boundary = 1; step(0, 0, 0);
    wr(2'd0, 8'h60); wr(2'd1, 8'h60); rx(8'h60);
    chk("R9 stop wins", 8'(tx_halt), 8'h01);

    phase = "R11 multidrop";
    wr(2'd3, 8'h04); rx(8'h22); rx(8'h23); rx(8'hA5); rx(8'h24);
    wr(2'd3, 8'h06); rx(8'h25); rx(8'hA5); rx(8'h26);
    cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 8'h04; rx(8'hA5);
    rx(8'h27);

    phase = "R12 soft reset";
    cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 8'h80; rx(8'h42);
    rx(8'h11); rx(8'h13);
    chk("R12 default stop char", 8'(recog_stat), 8'h03);

    phase = "random R3,R4,R6,R7,R8,R9,R10,R11";
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] pool [6];
      pool = '{8'h11, 8'h13, 8'h5A, 8'h00, 8'h7E, 8'hC3};
      tx_boundary = ($urandom_range(0, 3) != 0);
      stat_rd = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 19) == 0) begin
        cfg_we = 1;
        cfg_sel = 2'($urandom_range(0, 3));
        cfg_wdata = (cfg_sel == 2'd3) ? 8'($urandom_range(0, 63))
                                      : pool[$urandom_range(0, 5)];
        if ($urandom_range(0, 9) == 0) cfg_wdata[7] = 1;
      end
      step(1'($urandom_range(0, 1)), pool[$urandom_range(0, 5)],
           ($urandom_range(0, 4) == 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL [watchdog] run did not finish act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule